// File: doc/BRIEF.md
# Composite/component rate detector

This block decides whether an incoming serial video stream carries composite or component video by timing a line-reference signal that flips level on each timing reference the decoder finds. Component video flips the signal at both the start and the end of every line, so the flips arrive at the line rate. Composite video flips it once per line, so the flips arrive at half that rate and the spacing between them is twice as long. The block counts clock cycles between successive flips and compares each spacing with a threshold. The threshold that applies depends on the mode currently selected, so the two thresholds form a hysteresis band.

The output `modulus_o` selects the divide-by-two setting of the receiver's oscillator. High means composite, with divide-by-two enabled. Low means component. A change is applied only after a run of consecutive qualifying measurements. This run rejects the falsely slow flip rates that appear while the input is noisy or the supplies are still settling. Every change of `modulus_o` comes with a one-cycle `relock_o` pulse, which tells the sweep controller to reacquire lock. While the lock input is low, nothing is measured.

Top module: `rate_class_detector`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `modulus_o` is 0 and `relock_o` is 0. Reset also clears the qualification run.
- R2: A flip event is either edge of `hsync_i`. A measurement is the number of clock cycles between two successive flip events. The first flip after reset, or after `locked_i` rises, only starts a measurement and yields none.
- R3: While `modulus_o` is 0, a valid measurement strictly greater than `HI_TH` (default 300) advances the run. A valid measurement equal to or below `HI_TH` clears it.
- R4: While `modulus_o` is 1, a valid measurement strictly less than `LO_TH` (default 200, below `HI_TH`) advances the run. A valid measurement of `LO_TH` or more clears it. Spacings between the two thresholds therefore never change the mode in either state.
- R5: `modulus_o` inverts on the `QUAL_N`-th consecutive advancing measurement (default 8) and not before. A value of 1 means composite (divide-by-two on) and 0 means component. The run restarts from zero after each change.
- R6: A single contrary valid measurement in the middle of a run clears the run, so `QUAL_N` fresh advancing measurements are needed afterwards.
- R7: A spacing longer than `TIMEOUT` cycles (default 1000) is invalid. It neither advances nor clears the run.
- R8: `relock_o` is high for exactly one cycle, in the same cycle that `modulus_o` takes its new value. It is never high at any other time.
- R9: While `locked_i` is low, no measurement is made and the run is cleared. `modulus_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | Line-reference signal that flips on each detected timing reference (asynchronous) |
| locked_i | input | 1 | High while the receiver loop holds lock on the data |
| modulus_o | output | 1 | Mode select: 1 composite (divide-by-two), 0 component |
| relock_o | output | 1 | One-cycle pulse on every change of `modulus_o` |

## Verification
The hardest state to reach from the ports is a run that has been partly built and is then disturbed. That disturbance can be a single contrary spacing, an over-long spacing, or a loss of lock. Only the count of advancing measurements that follows shows whether the run was kept or cleared. The stimulus therefore schedules each flip against a running tally of the cycles since the previous one, so that every spacing is exact, including the spacing across the pauses where results are checked. It then builds runs of 4, 5 or 7 measurements, inserts the disturbance, and counts off exactly the number of further flips at which a kept run and a cleared run give different outputs.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    // state of the flip-event synchronizer
    typedef struct packed {
        logic [2:0] sh;
    } sync_state_t;

    // outcome of one spacing measurement
    typedef enum logic [1:0] {
        MEAS_NONE  = 2'd0,
        MEAS_OK    = 2'd1,
        MEAS_STALE = 2'd2
    } meas_kind_e;

endpackage

// File: rtl/rcd_toggle_sync.sv
module rcd_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic flip_o
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[DEPTH-2:0], sig_i};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign flip_o = st_q.sh[DEPTH-1] ^ st_q.sh[DEPTH-2];

endmodule

// File: rtl/rcd_period_meter.sv
module rcd_period_meter
    import rcd_pkg::*;
#(
    parameter int TIMEOUT = 1000,
    localparam int CW = $clog2(TIMEOUT + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flip_i,
    input  logic          locked_i,
    output meas_kind_e    kind_o,
    output logic [CW-1:0] period_o
);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        meas_kind_e    kind;
        logic [CW-1:0] per;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kind = MEAS_NONE;
        if (!locked_i) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (flip_i) begin
            if (st_q.armed) begin
                if (st_q.cnt > LIMIT) begin
                    st_d.kind = MEAS_STALE;
                end else begin
                    st_d.kind = MEAS_OK;
                    st_d.per  = st_q.cnt;
                end
            end
            st_d.armed = 1'b1;
            st_d.cnt   = CW'(1);
        end else if (st_q.cnt <= LIMIT) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{cnt: '0, armed: 1'b0, kind: MEAS_NONE, per: '0};
        else     st_q <= st_d;
    end

    assign kind_o   = st_q.kind;
    assign period_o = st_q.per;

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LIMIT + CW'(1));

    // R7
    valid_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (kind_o == MEAS_OK) |-> (period_o != '0 && period_o <= LIMIT));

    // R9
    no_meas_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> (kind_o == MEAS_NONE));

endmodule

// File: rtl/rcd_qualifier.sv
module rcd_qualifier
    import rcd_pkg::*;
#(
    parameter int CW     = 10,
    parameter int HI_TH  = 300,
    parameter int LO_TH  = 200,
    parameter int QUAL_N = 8,
    localparam int QW    = $clog2(QUAL_N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          locked_i,
    input  meas_kind_e    kind_i,
    input  logic [CW-1:0] period_i,
    output logic          modulus_o,
    output logic          relock_o
);
    localparam logic [QW-1:0] LAST = QW'(QUAL_N - 1);

    typedef struct packed {
        logic          mode;
        logic [QW-1:0] run;
        logic          chg;
    } st_t;

    st_t  st_d, st_q;
    logic favour;

    always_comb begin
        favour = st_q.mode ? (32'(period_i) < LO_TH) : (32'(period_i) > HI_TH);
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (!locked_i) begin
            st_d.run = '0;
        end else if (kind_i == MEAS_OK) begin
            if (!favour) begin
                st_d.run = '0;
            end else if (st_q.run == LAST) begin
                st_d.mode = ~st_q.mode;
                st_d.run  = '0;
                st_d.chg  = 1'b1;
            end else begin
                st_d.run = st_q.run + QW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: 1'b0, run: '0, chg: 1'b0};
        else     st_q <= st_d;
    end

    assign modulus_o = st_q.mode;
    assign relock_o  = st_q.chg;

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        relock_o |=> !relock_o);

    // R8
    change_has_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(modulus_o) |-> relock_o);

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.run < QW'(QUAL_N));

    // R9
    unlock_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> (st_q.run == '0 && $stable(modulus_o)));

    // R7
    stale_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_i && kind_i == MEAS_STALE) |=> $stable(st_q.run));

endmodule

// File: rtl/rate_class_detector.sv
module rate_class_detector
    import rcd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 1000,
    parameter int HI_TH       = 300,
    parameter int LO_TH       = 200,
    parameter int QUAL_N      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync_i,
    input  logic locked_i,
    output logic modulus_o,
    output logic relock_o
);
    localparam int CW = $clog2(TIMEOUT + 2);

    logic          flip;
    meas_kind_e    kind;
    logic [CW-1:0] period;

    rcd_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (hsync_i),
        .flip_o (flip)
    );

    rcd_period_meter #(.TIMEOUT(TIMEOUT)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .flip_i   (flip),
        .locked_i (locked_i),
        .kind_o   (kind),
        .period_o (period)
    );

    rcd_qualifier #(
        .CW     (CW),
        .HI_TH  (HI_TH),
        .LO_TH  (LO_TH),
        .QUAL_N (QUAL_N)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .locked_i  (locked_i),
        .kind_i    (kind),
        .period_i  (period),
        .modulus_o (modulus_o),
        .relock_o  (relock_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!modulus_o && !relock_o));

endmodule

// File: tb/tb_rate_class_detector.sv
module tb_rate_class_detector;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync = 1'b0;
    logic locked = 1'b1;
    logic modulus, relock;

    int checks = 0;
    int errors = 0;
    int since  = 0;
    int pulses = 0;
    int width  = 0;
    int maxw   = 0;
    int mismatch = 0;
    logic prev_mod = 1'b0;

    always #10 clk = ~clk;

    rate_class_detector dut (
        .clk       (clk),
        .rst       (rst),
        .hsync_i   (hsync),
        .locked_i  (locked),
        .modulus_o (modulus),
        .relock_o  (relock)
    );

    // pulse monitor, R8
    always @(posedge clk) begin
        if (rst) begin
            width    <= 0;
            prev_mod <= 1'b0;
        end else begin
            if (relock) begin
                pulses <= pulses + 1;
                width  <= width + 1;
                if (width + 1 > maxw) maxw <= width + 1;
            end else begin
                width <= 0;
            end
            if ((modulus != prev_mod) != relock) mismatch <= mismatch + 1;
            prev_mod <= modulus;
        end
    end

    localparam int NV = 15;
    // spacing, flips, expected mode, expected total pulses
    localparam int V_PER [NV] = '{100, 400, 400, 250, 150, 400, 150, 150, 250, 300, 301, 1200, 150, 1200, 150};
    localparam int V_CNT [NV] = '{ 10,   7,   1,  12,   5,   1,   7,   1,  12,  10,   8,   10,   4,    1,   4};
    localparam int V_MOD [NV] = '{  0,   0,   1,   1,   1,   1,   1,   0,   0,   0,   1,    1,   1,    1,   0};
    localparam int V_CHG [NV] = '{  0,   0,   1,   1,   1,   1,   1,   2,   2,   2,   3,    3,   3,    3,   4};
    localparam string V_REQ [NV] = '{"R3", "R5", "R5", "R4", "R4", "R6", "R6", "R5",
                                      "R4", "R3", "R3", "R7", "R7", "R7", "R7"};

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            since++;
        end
    endtask

    task automatic flip(input int p);
        tick(p - since);
        hsync = ~hsync;
        since = 0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check("R1", "mode in reset", modulus, 0);
        check("R1", "pulse in reset", relock, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mode after reset", modulus, 0);
        since = 0;
        flip(50);                       // R2: arms only
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < V_CNT[v]; k++) flip(V_PER[v]);
            tick(8);
            check(V_REQ[v], $sformatf("vector %0d mode", v), modulus, V_MOD[v]);
            check(V_REQ[v], $sformatf("vector %0d pulses", v), pulses, V_CHG[v]);
        end

        // R9: loss of lock clears a partial run
        for (int k = 0; k < 5; k++) flip(400);
        tick(8);
        locked = 1'b0;
        tick(20);
        locked = 1'b1;
        tick(4);
        flip(400);                      // R2: first flip after lock only arms
        for (int k = 0; k < 7; k++) flip(400);
        tick(8);
        check("R9", "mode after 7 post-lock", modulus, 0);
        flip(400);
        tick(8);
        check("R9", "mode after 8 post-lock", modulus, 1);
        check("R8", "pulses after relock run", pulses, 5);

        // R9: flips while unlocked are ignored
        locked = 1'b0;
        for (int k = 0; k < 12; k++) flip(150);
        tick(8);
        check("R9", "mode while unlocked", modulus, 1);
        check("R9", "pulses while unlocked", pulses, 5);
        locked = 1'b1;

        check("R8", "max pulse width", maxw, 1);
        check("R8", "mode change without pulse", mismatch, 0);

        // R1: reset mid-run returns to component
        rst = 1'b1;
        tick(3);
        check("R1", "mode in second reset", modulus, 0);
        check("R1", "pulse in second reset", relock, 0);
        rst = 1'b0;
        tick(2);
        check("R1", "mode after second reset", modulus, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule